// File: doc/BRIEF.md
# Triple 16-bit Timer Counter

Three independent 16-bit up-counters sit behind one small memory-mapped register bus and run from one shared clock. Each timer has an optional power-of-two prescaler, a control register for disabling, resetting and selecting interval mode, an interval (reload) value, three compare values, a sticky event status register and an event enable mask. Each timer drives its own interrupt line.

Software selects a timer by register address. Every register kind forms a group of three 32-bit words, one per timer. The counter either runs freely and wraps at its top value, or runs in interval mode and returns to zero after it reaches the programmed interval. Status bits record interval, compare and overflow events until software writes ones to clear them.

Top module: `tri_timer16`

## Requirements
- R1: After reset, each counter control word reads 0x01 (disabled), every count, interval, compare, clock control, status and enable word reads 0, and all interrupt lines are low.
- R2: Group base offsets are clock control 0x00, counter control 0x0C, count 0x18, interval 0x24, compares 0x30/0x3C/0x48, status 0x54, enable 0x60, and timer k (0..2) sits at base + 4k. Activity in one timer leaves the others' count words unchanged.
- R3: Clock control bit 0 turns the prescaler on and bits [4:1] hold N, so that the counter steps once every 2^(N+1) enabled clocks (0x9 gives 32). With bit 0 clear it steps on every enabled clock.
- R4: While counter control bit 0 is 1 the count holds its value.
- R5: Writing counter control with bit 4 set clears the count and the prescaler in that cycle. Bit 4 always reads back 0. Bit 5 is stored and read back with no effect on counting.
- R6: In free-running mode (control bit 1 clear) the count wraps from 0xFFFF to 0 and sets status bit 4.
- R7: With control bit 1 set, a step taken while the count equals the interval word returns the count to 0 and sets status bit 0.
- R8: Status bit n (n = 1..3) sets on the step at which the count takes the value of compare word n.
- R9: Writing the status word clears the bits written as 1 and keeps the others; an event arriving in the same cycle as its clear leaves the bit set.
- R10: Each timer's interrupt line is high exactly when some status bit is set and its matching enable bit is 1.
- R11: Writes to the count word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for bus and counters |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase; a write takes effect when psel, penable and pwrite are high |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 7 | Byte address of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid combinationally while psel is high |
| irq | output | 3 | One interrupt line per timer |

## Verification
The two functions that meet in one cycle are a software clear of a status bit and a fresh interval event that sets that same bit. The bench runs timer 0 in interval mode with a period of five clocks, counts edges from the enabling write, and lines up the status clear so that it lands exactly on the edge of the second wrap. The status word is then read with the counter frozen: it must still show the interval bit, while a later clear with no event removes it.

// File: rtl/tri_timer16.sv
module tri_timer16 #(
  parameter int W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [6:0]  paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  output logic [2:0]  irq
);
  localparam int NT = 3;
  localparam int PW = 16;

  logic [4:0]   clkc [NT];
  logic [2:0]   ctl  [NT];
  logic [W-1:0] cnt  [NT];
  logic [W-1:0] ivl  [NT];
  logic [W-1:0] mat  [NT][3];
  logic [4:0]   isr  [NT];
  logic [4:0]   ier  [NT];
  logic [PW-1:0] pc  [NT];

  logic [NT-1:0] run, tick, wk;
  logic [W-1:0]  nxt [NT];
  logic [4:0]    ev  [NT];

  logic       wr_en;
  logic [4:0] widx;
  logic [3:0] grp;
  logic [1:0] sel;

  assign wr_en = psel & penable & pwrite;
  assign widx  = paddr[6:2];
  assign grp   = 4'(widx / 5'd3);
  assign sel   = 2'(widx % 5'd3);

  always_comb begin
    logic [PW-1:0] m;
    logic hit;
    for (int k = 0; k < NT; k++) begin
      wk[k]   = wr_en && (sel == 2'(k));
      m       = {PW{1'b1}} >> (4'd15 - clkc[k][4:1]);
      run[k]  = !ctl[k][0];
      tick[k] = run[k] && (!clkc[k][0] || ((pc[k] & m) == m));
      hit     = ctl[k][1] && (cnt[k] == ivl[k]);
      nxt[k]  = hit ? '0 : cnt[k] + 1'b1;
      ev[k][0] = tick[k] && hit;
      ev[k][4] = tick[k] && !ctl[k][1] && (&cnt[k]);
      for (int n = 0; n < 3; n++)
        ev[k][n+1] = tick[k] && (nxt[k] == mat[k][n]);
      irq[k]  = |(isr[k] & ier[k]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NT; k++) begin
        clkc[k] <= '0;
        ctl[k]  <= 3'b001;
        cnt[k]  <= '0;
        ivl[k]  <= '0;
        isr[k]  <= '0;
        ier[k]  <= '0;
        pc[k]   <= '0;
        for (int n = 0; n < 3; n++) mat[k][n] <= '0;
      end
    end else begin
      for (int k = 0; k < NT; k++) begin
        if (wk[k] && grp == 4'd0) clkc[k] <= pwdata[4:0];
        if (wk[k] && grp == 4'd1) ctl[k] <= {pwdata[5], pwdata[1], pwdata[0]};
        if (wk[k] && grp == 4'd3) ivl[k] <= pwdata[W-1:0];
        for (int n = 0; n < 3; n++)
          if (wk[k] && grp == 4'(4 + n)) mat[k][n] <= pwdata[W-1:0];
        if (wk[k] && grp == 4'd8) ier[k] <= pwdata[4:0];
        isr[k] <= (isr[k] & ~((wk[k] && grp == 4'd7) ? pwdata[4:0] : 5'd0)) | ev[k];
        if (wk[k] && grp == 4'd1 && pwdata[4]) begin
          cnt[k] <= '0;
          pc[k]  <= '0;
        end else if (run[k]) begin
          pc[k] <= pc[k] + 1'b1;
          if (tick[k]) cnt[k] <= nxt[k];
        end
      end
    end
  end

  always_comb begin
    prdata = '0;
    if (psel && sel != 2'd3) begin
      case (grp)
        4'd0: prdata = 32'(clkc[sel]);
        4'd1: prdata = {26'd0, ctl[sel][2], 3'b000, ctl[sel][1], ctl[sel][0]};
        4'd2: prdata = 32'(cnt[sel]);
        4'd3: prdata = 32'(ivl[sel]);
        4'd4: prdata = 32'(mat[sel][0]);
        4'd5: prdata = 32'(mat[sel][1]);
        4'd6: prdata = 32'(mat[sel][2]);
        4'd7: prdata = 32'(isr[sel]);
        4'd8: prdata = 32'(ier[sel]);
        default: prdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/tri_timer16_chk.sv
module tri_timer16_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         psel,
  input logic         penable,
  input logic         pwrite,
  input logic [6:0]   paddr,
  input logic [31:0]  pwdata,
  input logic [31:0]  prdata,
  input logic [2:0]   irq,
  input logic [W-1:0] cnt0,
  input logic         dis0,
  input logic [4:0]   isr0,
  input logic [4:0]   ier0
);
  logic wr;
  assign wr = psel && penable && pwrite;

  AST_RST_BIT_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !pwrite && (paddr == 7'h0C || paddr == 7'h10 || paddr == 7'h14)) |-> !prdata[4]); // R5

  AST_HOLD_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (dis0 && !(wr && paddr == 7'h0C && pwdata[4])) |=> $stable(cnt0)); // R4

  AST_COUNT_STEPS_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt0 == $past(cnt0) || cnt0 == W'($past(cnt0) + 1'b1) || cnt0 == '0)); // R11

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && paddr == 7'h54) |=> ((isr0 & $past(isr0)) == $past(isr0))); // R9

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq[0] |-> ((isr0 & ier0) != 5'd0)); // R10
endmodule

bind tri_timer16 tri_timer16_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq),
  .cnt0(cnt[0]), .dis0(ctl[0][0]), .isr0(isr[0]), .ier0(ier[0])
);

// File: tb/test_tri_timer16.sv
module test_tri_timer16;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [6:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [2:0] irq;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  tri_timer16 i_tri_timer16 (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    #1 d = prdata;
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [6:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic t_reset;
    rd_chk("R1 ctl t0", 7'h0C, 32'h1);
    rd_chk("R1 ctl t2", 7'h14, 32'h1);
    rd_chk("R1 count t0", 7'h18, 32'h0);
    rd_chk("R1 enable t1", 7'h64, 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
  endtask

  task automatic t_prescale;
    wr(7'h04, 32'h9);
    wr(7'h10, 32'h10);
    repeat (167) @(negedge clk);
    wr(7'h10, 32'h01);
    rd_chk("R3 prescaled count t1", 7'h1C, 32'd5);
    rd_chk("R2 t0 untouched", 7'h18, 32'd0);
    repeat (20) @(negedge clk);
    rd_chk("R4 held while disabled", 7'h1C, 32'd5);
  endtask

  task automatic t_plain;
    wr(7'h0C, 32'h10);
    repeat (10) @(negedge clk);
    wr(7'h0C, 32'h01);
    rd_chk("R3 undivided count t0", 7'h18, 32'd13);
    wr(7'h18, 32'h1234);
    rd_chk("R11 count not writable", 7'h18, 32'd13);
    wr(7'h0C, 32'h31);
    rd_chk("R5 reset bit reads 0, bit5 kept", 7'h0C, 32'h21);
    rd_chk("R5 count cleared", 7'h18, 32'd0);
  endtask

  task automatic t_wrap;
    wr(7'h14, 32'h10);
    repeat (65540) @(negedge clk);
    wr(7'h14, 32'h01);
    rd_chk("R6 wrapped count t2", 7'h20, 32'd7);
    rd_chk("R6 overflow and zero compares t2", 7'h5C, 32'h1E);
    check("R10 irq masked", 32'(irq), 32'h0);
    wr(7'h68, 32'h10);
    check("R10 irq enabled", 32'(irq), 32'h4);
    wr(7'h68, 32'h01);
    check("R10 irq other enable", 32'(irq), 32'h0);
    wr(7'h5C, 32'h10);
    rd_chk("R9 partial clear", 7'h5C, 32'h0E);
    wr(7'h5C, 32'h0E);
    rd_chk("R9 full clear", 7'h5C, 32'h0);
  endtask

  task automatic t_interval_collision;
    wr(7'h24, 32'd4);
    wr(7'h30, 32'h100);
    wr(7'h3C, 32'h100);
    wr(7'h48, 32'h100);
    wr(7'h0C, 32'h12);
    repeat (7) @(negedge clk);
    wr(7'h54, 32'h01);
    wr(7'h0C, 32'h03);
    rd_chk("R9 event beats clear", 7'h54, 32'h01);
    rd_chk("R7 interval count", 7'h18, 32'd3);
    wr(7'h54, 32'h01);
    rd_chk("R7 interval bit cleared", 7'h54, 32'h0);
  endtask

  task automatic t_match;
    wr(7'h04, 32'h0);
    wr(7'h34, 32'd6);
    wr(7'h40, 32'd9);
    wr(7'h4C, 32'h200);
    wr(7'h58, 32'h1F);
    wr(7'h10, 32'h10);
    repeat (4) @(negedge clk);
    wr(7'h10, 32'h01);
    rd_chk("R8 count t1", 7'h1C, 32'd7);
    rd_chk("R8 compare 1 hit", 7'h58, 32'h02);
    wr(7'h10, 32'h00);
    wr(7'h10, 32'h01);
    rd_chk("R8 count resumed", 7'h1C, 32'd10);
    rd_chk("R8 compare 2 hit", 7'h58, 32'h06);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_prescale;
    t_plain;
    t_wrap;
    t_interval_collision;
    t_match;
    finish_run;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end
endmodule